// File: doc/BRIEF.md
# SMBus Byte-Data Read Host

This block is a bus master for a two-wire system management bus. Each start command runs one complete byte-data read. Software uses a byte-wide register file to load a target address and a command byte and to select a protocol. A write to the control register with the launch bit set then starts the transaction. The sequencer sends the target address with the write direction and then the command byte. It issues a repeated START, sends the address again with the read direction, and clocks in one byte. It answers that byte with a NACK and ends with a STOP. The received byte goes into the data register.

Clock and data are open-drain. The outputs `scl_oe` and `sda_oe` pull their line low when high. A bit engine divides every bus bit into four quarter phases of `QDIV` system cycles each. While the engine has released SCL, it waits for the line to actually read high before counting, which allows a target to hold the clock low.

Software polls a live busy bit and sticky event flags, and clears the flags by writing ones. A missing acknowledge, or a protocol code other than 2, sets the failure flag.

Sequencer states:
- `S_IDLE`
- `S_START`
- `S_ADDR_WR`
- `S_CMD`
- `S_RESTART`
- `S_ADDR_RD`
- `S_DATA`
- `S_STOP`

Transitions:
- `S_IDLE` to `S_START`: launch with protocol 2.
- `S_START` to `S_ADDR_WR`, and `S_RESTART` to `S_ADDR_RD`: the START operation completes.
- `S_ADDR_WR` to `S_CMD`, `S_CMD` to `S_RESTART`, and `S_ADDR_RD` to `S_DATA`: the acknowledge bit reads low.
- `S_ADDR_WR`, `S_CMD` or `S_ADDR_RD` to `S_STOP`: the acknowledge bit reads high (NACK).
- `S_DATA` to `S_STOP`: after the ninth bit.
- `S_STOP` to `S_IDLE`: the STOP operation completes.

Bit-engine states:
- `E_IDLE` to `E_RUN`: an operation is accepted.
- `E_RUN` to `E_IDLE`: the last quarter phase ends.

Top module: `smbh_host`

## Requirements
- R1: After reset, every register reads 0x00 and both line enables are low (lines released).
- R2: The register map is as follows.
  - Offset 0x3: command byte, read/write.
  - Offset 0x4: address byte, with the target in bits 7:1 and the direction in bit 0.
  - Offset 0x5: data byte, read/write.
  - Offset 0x2: control. Bits 4:2 read back as the protocol field, and launch bit 6 always reads 0.
  - Offset 0x0: status.
- R3: Status bit 0 (busy) reads 1 from the cycle after a launch with protocol 2 until the transaction ends.
- R4: A protocol-2 transaction puts this sequence on the bus: START, address+W, command, repeated START, address+R, one data byte answered by NACK, STOP. That is exactly two START conditions and one STOP.
- R5: On success, the received byte lands in the data register. Status bit 1 is set in the same cycle that busy clears.
- R6: If the address or the command byte is not acknowledged, status bit 2 is set, a STOP is issued, busy clears, and the data register keeps its prior value.
- R7: A launch with a protocol code other than 2 sets status bit 2, never raises busy, and produces no SCL activity.
- R8: A control write while busy is ignored: it neither starts a transaction nor changes the protocol field.
- R9: Writing 1 to a status bit in 4:1 clears that bit, and writing 0 leaves it unchanged.
- R10: SDA changes only while SCL is driven low, except during START and STOP conditions.
- R11: While SCL is released in the high phases, the engine holds its phase until the line reads high, so a target holding SCL low delays the transaction without corrupting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| scl_i | input | 1 | Sensed clock line level |
| scl_oe | output | 1 | Pull clock line low |
| sda_i | input | 1 | Sensed data line level |
| sda_oe | output | 1 | Pull data line low |

## Verification
The assertions assume the following about the block's inputs:
- `scl_i` and `sda_i` are the wired-AND of this master's enables and the target's drivers.
- The target moves SDA only while SCL is low.
- The target holds SCL low only after the master has pulled it low.

The bench's target model follows these rules. It updates its SDA driver one cycle after it sees a falling SCL edge. It stretches the clock only from such a falling edge. It changes nothing while SCL is high. Register writes are single-cycle strobes driven between clock edges.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_START,
        OP_STOP,
        OP_BIT
    } bus_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_ADDR_WR,
        S_CMD,
        S_RESTART,
        S_ADDR_RD,
        S_DATA,
        S_STOP
    } seq_state_e;

    typedef enum logic {
        E_IDLE,
        E_RUN
    } eng_state_e;

    localparam logic [2:0] OFS_STATUS = 3'd0;
    localparam logic [2:0] OFS_CTRL   = 3'd2;
    localparam logic [2:0] OFS_CMD    = 3'd3;
    localparam logic [2:0] OFS_ADDR   = 3'd4;
    localparam logic [2:0] OFS_DATA   = 3'd5;

    localparam logic [2:0] PROTO_BYTE_DATA_RD = 3'd2;
    localparam int         LAUNCH_BIT         = 6;
endpackage

// File: rtl/smbh_bit_engine.sv
module smbh_bit_engine
    import smbh_pkg::*;
#(
    parameter int QDIV = 25
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    op_valid,
    input  bus_op_e op,
    input  logic    op_bit,
    input  logic    scl_i,
    input  logic    sda_i,
    output logic    op_busy,
    output logic    op_done,
    output logic    rx_bit,
    output logic    scl_oe,
    output logic    sda_oe
);
    localparam int             CW       = (QDIV > 1) ? $clog2(QDIV) : 1;
    localparam logic [CW-1:0]  CNT_LAST = CW'(QDIV - 1);

    eng_state_e    st_q;
    logic [1:0]    ph_q;
    logic [CW-1:0] cnt_q;
    bus_op_e       op_q;
    logic          bit_q;
    logic          rx_q;
    logic          scl_oe_q;
    logic          sda_oe_q;
    logic          stall;
    logic          tick;

    // returns {pull scl low, pull sda low} for one quarter phase
    function automatic logic [1:0] lines(input bus_op_e o, input logic b, input logic [1:0] ph);
        logic [1:0] r;
        r = 2'b00;
        unique case (o)
            OP_START: begin
                unique case (ph)
                    2'd0: r = 2'b10;
                    2'd1: r = 2'b00;
                    2'd2: r = 2'b01;
                    default: r = 2'b11;
                endcase
            end
            OP_STOP: begin
                unique case (ph)
                    2'd0: r = 2'b11;
                    2'd1: r = 2'b01;
                    default: r = 2'b00;
                endcase
            end
            default: begin
                r = {(ph == 2'd0) || (ph == 2'd3), ~b};
            end
        endcase
        return r;
    endfunction

    assign stall   = (st_q == E_RUN) && ((ph_q == 2'd1) || (ph_q == 2'd2)) && !scl_i;
    assign tick    = (st_q == E_RUN) && !stall && (cnt_q == CNT_LAST);
    assign op_done = tick && (ph_q == 2'd3);
    assign op_busy = (st_q == E_RUN);
    assign rx_bit  = rx_q;
    assign scl_oe  = scl_oe_q;
    assign sda_oe  = sda_oe_q;

    // state register: engine state, phase and divider
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= E_IDLE;
            ph_q  <= 2'd0;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                E_IDLE: begin
                    if (op_valid) begin
                        st_q  <= E_RUN;
                        ph_q  <= 2'd0;
                        cnt_q <= '0;
                    end
                end
                default: begin
                    if (!stall) begin
                        if (cnt_q != CNT_LAST) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else begin
                            cnt_q <= '0;
                            if (ph_q == 2'd3) st_q <= E_IDLE;
                            else              ph_q <= ph_q + 2'd1;
                        end
                    end
                end
            endcase
        end
    end

    // outputs: latched operation, line drivers, received bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OP_STOP;
            bit_q    <= 1'b1;
            rx_q     <= 1'b1;
            scl_oe_q <= 1'b0;
            sda_oe_q <= 1'b0;
        end else if (st_q == E_IDLE) begin
            if (op_valid) begin
                op_q                 <= op;
                bit_q                <= op_bit;
                {scl_oe_q, sda_oe_q} <= lines(op, op_bit, 2'd0);
            end
        end else if (tick) begin
            if (ph_q == 2'd2) rx_q <= sda_i;
            if (ph_q != 2'd3) {scl_oe_q, sda_oe_q} <= lines(op_q, bit_q, ph_q + 2'd1);
        end
    end

    // R10: with scl released, sda may only move inside START/STOP
    a_r10_sda_moves_with_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe != $past(sda_oe)) && !$past(scl_oe)) |-> (op_q != OP_BIT));

    // R11: a target holding scl low freezes the phase
    a_r11_wait_for_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == E_RUN) && (ph_q == 2'd1) && !scl_i) |=> ((ph_q == 2'd1) && (st_q == E_RUN)));
endmodule

// File: rtl/smbh_sequencer.sv
module smbh_sequencer
    import smbh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [2:0]        launch_proto,
    input  logic [6:0]        tgt_addr,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              rx_bit,
    output logic              op_valid,
    output bus_op_e           op,
    output logic              op_bit,
    output logic              busy,
    output logic              fin_ok,
    output logic              fin_err,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam int         BN_W     = $clog2(BYTE_W + 1);
    localparam logic [BN_W-1:0] LAST_BIT = BN_W'(BYTE_W);

    seq_state_e        state_q, state_d;
    logic [BN_W-1:0]   bitn_q, bitn_d;
    logic [BYTE_W-1:0] sh_q, sh_d;
    logic [BYTE_W-1:0] cmd_q, cmd_d;
    logic [6:0]        tgt_q, tgt_d;
    logic              nack_q, nack_d;
    logic              good_launch;

    assign good_launch = launch && (launch_proto == PROTO_BYTE_DATA_RD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bitn_q  <= '0;
            sh_q    <= '0;
            cmd_q   <= '0;
            tgt_q   <= '0;
            nack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            bitn_q  <= bitn_d;
            sh_q    <= sh_d;
            cmd_q   <= cmd_d;
            tgt_q   <= tgt_d;
            nack_q  <= nack_d;
        end
    end

    always_comb begin
        state_d = state_q;
        bitn_d  = bitn_q;
        sh_d    = sh_q;
        cmd_d   = cmd_q;
        tgt_d   = tgt_q;
        nack_d  = nack_q;
        unique case (state_q)
            S_IDLE: begin
                if (good_launch) begin
                    state_d = S_START;
                    nack_d  = 1'b0;
                    tgt_d   = tgt_addr;
                    cmd_d   = cmd_byte;
                end
            end
            S_START, S_RESTART: begin
                if (eng_done) begin
                    state_d = (state_q == S_START) ? S_ADDR_WR : S_ADDR_RD;
                    sh_d    = {tgt_q, (state_q == S_RESTART)};
                    bitn_d  = '0;
                end
            end
            S_ADDR_WR, S_CMD, S_ADDR_RD: begin
                if (eng_done) begin
                    if (bitn_q != LAST_BIT) begin
                        sh_d   = {sh_q[BYTE_W-2:0], 1'b0};
                        bitn_d = bitn_q + 1'b1;
                    end else if (rx_bit) begin
                        nack_d  = 1'b1;
                        state_d = S_STOP;
                    end else begin
                        bitn_d = '0;
                        if (state_q == S_ADDR_WR) begin
                            state_d = S_CMD;
                            sh_d    = cmd_q;
                        end else if (state_q == S_CMD) begin
                            state_d = S_RESTART;
                        end else begin
                            state_d = S_DATA;
                        end
                    end
                end
            end
            S_DATA: begin
                if (eng_done) begin
                    if (bitn_q != LAST_BIT) begin
                        sh_d   = {sh_q[BYTE_W-2:0], rx_bit};
                        bitn_d = bitn_q + 1'b1;
                    end else begin
                        state_d = S_STOP;
                    end
                end
            end
            S_STOP: begin
                if (eng_done) state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        op_valid = (state_q != S_IDLE) && !eng_busy;
        op       = OP_BIT;
        op_bit   = 1'b1;
        unique case (state_q)
            S_START, S_RESTART: op = OP_START;
            S_STOP:             op = OP_STOP;
            S_ADDR_WR, S_CMD, S_ADDR_RD: op_bit = (bitn_q == LAST_BIT) ? 1'b1 : sh_q[BYTE_W-1];
            default: ;
        endcase
        busy    = (state_q != S_IDLE);
        fin_ok  = (state_q == S_STOP) && eng_done && !nack_q;
        fin_err = ((state_q == S_STOP) && eng_done && nack_q) ||
                  ((state_q == S_IDLE) && launch && !good_launch);
        rx_byte = sh_q;
    end

    // R4: bus engine is quiet whenever the sequencer is idle
    a_r4_idle_engine_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> !eng_busy);

    // R5/R6: a finish report is followed by an idle sequencer
    a_r5_finish_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_ok || (fin_err && eng_done)) |=> (state_q == S_IDLE));

    // R7: an unsupported protocol launch never leaves idle
    a_r7_bad_proto_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE) && launch && (launch_proto != PROTO_BYTE_DATA_RD)) |=> (state_q == S_IDLE));

    a_r4_bit_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bitn_q <= LAST_BIT);
endmodule

// File: rtl/smbh_regfile.sv
module smbh_regfile
    import smbh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              fin_ok,
    input  logic              fin_err,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              launch,
    output logic [2:0]        launch_proto,
    output logic [6:0]        tgt_addr,
    output logic [BYTE_W-1:0] cmd_byte
);
    localparam int NFLAG = 4;

    logic [2:0]        proto_q;
    logic [BYTE_W-1:0] cmd_q;
    logic [BYTE_W-1:0] addr_q;
    logic [BYTE_W-1:0] data_q;
    logic [NFLAG:1]    flag_q;
    logic [NFLAG:1]    flag_set;
    logic              wr_status, wr_ctrl;

    assign wr_status    = reg_wr && (reg_addr == OFS_STATUS);
    assign wr_ctrl      = reg_wr && (reg_addr == OFS_CTRL) && !busy;
    assign launch       = wr_ctrl && reg_wdata[LAUNCH_BIT];
    assign launch_proto = reg_wdata[4:2];
    assign tgt_addr     = addr_q[7:1];
    assign cmd_byte     = cmd_q;
    assign flag_set     = {2'b00, fin_err, fin_ok};

    for (genvar i = 1; i <= NFLAG; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          f_q <= 1'b0;
            else if (flag_set[i])                f_q <= 1'b1;
            else if (wr_status && reg_wdata[i])  f_q <= 1'b0;
        end
        assign flag_q[i] = f_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            proto_q <= '0;
            cmd_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            if (wr_ctrl) proto_q <= reg_wdata[4:2];
            if (reg_wr && (reg_addr == OFS_CMD))  cmd_q  <= reg_wdata;
            if (reg_wr && (reg_addr == OFS_ADDR)) addr_q <= reg_wdata;
            if (fin_ok)                                data_q <= rx_byte;
            else if (reg_wr && (reg_addr == OFS_DATA)) data_q <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_STATUS: reg_rdata = {3'b000, flag_q, busy};
            OFS_CTRL:   reg_rdata = {3'b000, proto_q, 2'b00};
            OFS_CMD:    reg_rdata = cmd_q;
            OFS_ADDR:   reg_rdata = addr_q;
            OFS_DATA:   reg_rdata = data_q;
            default:    reg_rdata = '0;
        endcase
    end

    // R8: control writes during a transaction leave the protocol field alone
    a_r8_ctrl_locked_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == OFS_CTRL) && busy) |=> $stable(proto_q));

    // R6: a failure leaves the data register as it was
    a_r6_fail_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (fin_err && !(reg_wr && (reg_addr == OFS_DATA))) |=> $stable(data_q));
endmodule

// File: rtl/smbh_host.sv
module smbh_host
    import smbh_pkg::*;
#(
    parameter int QDIV = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_i,
    output logic       scl_oe,
    input  logic       sda_i,
    output logic       sda_oe
);
    logic              launch;
    logic [2:0]        launch_proto;
    logic [6:0]        tgt_addr;
    logic [BYTE_W-1:0] cmd_byte;
    logic              busy, fin_ok, fin_err;
    logic [BYTE_W-1:0] rx_byte;
    logic              op_valid, op_bit, eng_busy, eng_done, rx_bit;
    bus_op_e           op;

    smbh_regfile u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .busy         (busy),
        .fin_ok       (fin_ok),
        .fin_err      (fin_err),
        .rx_byte      (rx_byte),
        .launch       (launch),
        .launch_proto (launch_proto),
        .tgt_addr     (tgt_addr),
        .cmd_byte     (cmd_byte)
    );

    smbh_sequencer u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_proto (launch_proto),
        .tgt_addr     (tgt_addr),
        .cmd_byte     (cmd_byte),
        .eng_busy     (eng_busy),
        .eng_done     (eng_done),
        .rx_bit       (rx_bit),
        .op_valid     (op_valid),
        .op           (op),
        .op_bit       (op_bit),
        .busy         (busy),
        .fin_ok       (fin_ok),
        .fin_err      (fin_err),
        .rx_byte      (rx_byte)
    );

    smbh_bit_engine #(.QDIV(QDIV)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op       (op),
        .op_bit   (op_bit),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .op_busy  (eng_busy),
        .op_done  (eng_done),
        .rx_bit   (rx_bit),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );

    // R3: busy rises only through an accepted launch
    a_r3_busy_needs_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(launch));
endmodule

// File: tb/tb_smbh_host.sv
`timescale 1ns/1ps
module tb_smbh_host;
    localparam int QDIV = 4;
    localparam logic [6:0] SLV = 7'h2D;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe;
    logic       slv_sda_low = 1'b0;
    logic       slv_scl_low;
    wire        scl_line = !(scl_oe || slv_scl_low);
    wire        sda_line = !(sda_oe || slv_sda_low);

    always #2 clk = ~clk;

    smbh_host #(.QDIV(QDIV)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    int n_chk = 0, n_fail = 0;
    bit all_done = 1'b0;

    function automatic logic [7:0] mem(input logic [7:0] o);
        return (o * 8'd7) ^ 8'hA5;
    endfunction

    // ---------------- target model ----------------
    bit nack_addr_en = 0, nack_cmd_en = 0, stretch_en = 0;
    int mode = 0, bitc = 0, stretch_cnt = 0;
    int n_start = 0, n_stop = 0, n_fall = 0, n_sdahi = 0;
    logic [7:0] sh = 0, off = 0, tx = 0;
    logic rw = 0, master_nack = 0, p_scl = 1, p_sda = 1;
    logic [7:0] tx_next;
    always_comb tx_next = mem(off);
    assign slv_scl_low = (stretch_cnt > 0);

    always @(posedge clk) begin
        p_scl <= scl_line;
        p_sda <= sda_line;
        if (stretch_cnt > 0) stretch_cnt <= stretch_cnt - 1;
        if (p_scl && scl_line && (p_sda != sda_line)) begin
            n_sdahi <= n_sdahi + 1;
            if (!sda_line) begin
                n_start <= n_start + 1; mode <= 1; bitc <= 0; slv_sda_low <= 0;
            end else begin
                n_stop <= n_stop + 1; mode <= 0; slv_sda_low <= 0;
            end
        end else if (!p_scl && scl_line) begin
            if ((mode == 1 || mode == 2) && bitc < 8) begin
                sh <= {sh[6:0], sda_line}; bitc <= bitc + 1;
            end else if (mode == 3) begin
                if (bitc == 8) master_nack <= sda_line;
                bitc <= bitc + 1;
            end
        end else if (p_scl && !scl_line) begin
            n_fall <= n_fall + 1;
            if (stretch_en) stretch_cnt <= 20;
            if (mode == 1 || mode == 2) begin
                if (bitc == 8) begin
                    if ((mode == 1) ? (sh[7:1] == SLV && !nack_addr_en) : !nack_cmd_en) begin
                        slv_sda_low <= 1; bitc <= 9;
                        if (mode == 1) rw <= sh[0]; else off <= sh;
                    end else mode <= 0;
                end else if (bitc == 9) begin
                    slv_sda_low <= 0;
                    if (mode == 1 && rw) begin
                        mode <= 3; tx <= tx_next; slv_sda_low <= !tx_next[7]; bitc <= 0;
                    end else if (mode == 1) begin
                        mode <= 2; bitc <= 0;
                    end else mode <= 4;
                end
            end else if (mode == 3) begin
                if (bitc < 8) slv_sda_low <= !tx[7 - bitc];
                else          slv_sda_low <= 0;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    typedef struct { logic [7:0] stat; logic [7:0] data; string tag; } item_t;
    item_t exp_q[$];
    item_t act_q[$];

    initial begin : monitor
        item_t a, e;
        forever begin
            @(negedge clk);
            if (act_q.size() > 0 && exp_q.size() > 0) begin
                a = act_q.pop_front();
                e = exp_q.pop_front();
                chk_eq({e.tag, " final status"}, a.stat, e.stat);
                chk_eq({e.tag, " data register"}, a.data, e.data);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    // driver: program, launch, poll, collect
    task automatic do_read(input logic [6:0] tgt, input logic [7:0] ofs, input logic [2:0] pr,
                           input logic [7:0] preset, input logic [7:0] exp_stat,
                           input logic [7:0] exp_data, input string tag, input bit mid_start);
        item_t e, a;
        logic [7:0] s, d;
        int s0, p0, f0, h0;
        bit idle_seen;
        e.stat = exp_stat; e.data = exp_data; e.tag = tag;
        exp_q.push_back(e);
        wr(3'd0, 8'h1E);
        wr(3'd4, {tgt, 1'b1});
        wr(3'd3, ofs);
        wr(3'd5, preset);
        master_nack = 0;
        s0 = n_start; p0 = n_stop; f0 = n_fall; h0 = n_sdahi;
        wr(3'd2, 8'h40 | {3'b000, pr, 2'b00});
        rd(3'd0, s);
        if (pr == 3'd2) chk_eq({tag, " R3 busy after launch"}, s[0], 1'b1);
        else            chk_eq({tag, " R7 busy never rises"}, s[0], 1'b0);
        if (mid_start) begin
            wr(3'd2, 8'h5C);
            rd(3'd2, d);
            chk_eq({tag, " R8 control unchanged while busy"}, d, 8'h08);
            rd(3'd0, s);
            chk_eq({tag, " R8 still busy"}, s[0], 1'b1);
        end
        idle_seen = 0;
        for (int i = 0; i < 8000 && !idle_seen; i++) begin
            rd(3'd0, s);
            if (!s[0]) idle_seen = 1;
        end
        chk_eq({tag, " R5 event flag present when busy clears"}, (s[7:1] != 0), 1'b1);
        rd(3'd0, s);
        rd(3'd5, d);
        a.stat = s; a.data = d; a.tag = tag;
        act_q.push_back(a);
        if (pr != 3'd2) begin
            chk_eq({tag, " R7 no scl activity"}, n_fall - f0, 0);
        end else if (exp_stat == 8'h02) begin
            chk_eq({tag, " R4 start count"}, n_start - s0, 2);
            chk_eq({tag, " R4 stop count"}, n_stop - p0, 1);
            chk_eq({tag, " R4 master nack on data"}, master_nack, 1'b1);
            chk_eq({tag, " R10 sda moves with scl high only at start/stop"}, n_sdahi - h0, 3);
        end else begin
            chk_eq({tag, " R6 stop issued"}, n_stop - p0, 1);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, v); chk_eq("R1 status reset", v, 8'h00);
        rd(3'd2, v); chk_eq("R1 control reset", v, 8'h00);
        rd(3'd3, v); chk_eq("R1 command reset", v, 8'h00);
        rd(3'd4, v); chk_eq("R1 address reset", v, 8'h00);
        rd(3'd5, v); chk_eq("R1 data reset", v, 8'h00);
        chk_eq("R1 lines released", {scl_oe, sda_oe}, 2'b00);
        // R2 readback
        wr(3'd3, 8'hA7); rd(3'd3, v); chk_eq("R2 command readback", v, 8'hA7);
        wr(3'd4, 8'h5B); rd(3'd4, v); chk_eq("R2 address readback", v, 8'h5B);
        wr(3'd5, 8'h99); rd(3'd5, v); chk_eq("R2 data readback", v, 8'h99);
        wr(3'd2, 8'h0C); rd(3'd2, v); chk_eq("R2 control protocol field", v, 8'h0C);
        // transactions
        do_read(SLV, 8'h10, 3'd2, 8'h00, 8'h02, mem(8'h10), "R5 read 0x10", 0);
        rd(3'd2, v); chk_eq("R2 launch bit reads 0", v, 8'h08);
        do_read(SLV, 8'hF3, 3'd2, 8'h3C, 8'h02, mem(8'hF3), "R5 read 0xF3", 0);
        do_read(7'h11, 8'h20, 3'd2, 8'h3C, 8'h04, 8'h3C, "R6 address nack", 0);
        nack_cmd_en = 1;
        do_read(SLV, 8'h21, 3'd2, 8'h77, 8'h04, 8'h77, "R6 command nack", 0);
        nack_cmd_en = 0;
        do_read(SLV, 8'h22, 3'd5, 8'h66, 8'h04, 8'h66, "R7 bad protocol", 0);
        do_read(SLV, 8'h44, 3'd2, 8'h00, 8'h02, mem(8'h44), "R8 start while busy", 1);
        // R9 write-one-to-clear
        wr(3'd0, 8'h04); rd(3'd0, v); chk_eq("R9 writing 1 to other bit keeps flag", v, 8'h02);
        wr(3'd0, 8'h00); rd(3'd0, v); chk_eq("R9 writing 0 keeps flag", v, 8'h02);
        wr(3'd0, 8'h02); rd(3'd0, v); chk_eq("R9 writing 1 clears flag", v, 8'h00);
        // R11 clock stretching
        stretch_en = 1;
        do_read(SLV, 8'h5E, 3'd2, 8'h00, 8'h02, mem(8'h5E), "R11 stretched read", 0);
        stretch_en = 0;
        while (act_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
        all_done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule